// File: doc/BRIEF.md
# Accumulator ALU Instruction Executor

This block is the execute stage of a small single-accumulator core with 14-bit instruction words. Each cycle that `inValid` is high, it decodes the instruction. It takes the working register W, the operand that the register file has already fetched for the addressed location, and the current carry, half-carry and zero flags. One clock later it presents a registered result along with its write target, either W or the file register. It also presents the three flag values the status register should take next, and a skip request that the sequencer uses to drop the following instruction.

The block covers the file-register arithmetic and logic forms, the literal forms, the single-bit set, clear and test forms, and the two small groups that clear W, clear a register or store W. It does not carry out control opcodes such as sleep, watchdog clear, return, timer-mode load and port-direction load. It only flags them on a one-hot strobe vector so that neighbouring logic can act on them. Any encoding it does not recognise behaves as an empty slot.

Top module: `alu_exec_top`

## Requirements
- R1: For file-register forms the opcode sits in bits 13:8, the destination bit in bit 7 and the address in bits 6:0. Destination 0 drives `toFile`=0 (write W) and 1 drives `toFile`=1. All outputs are registered and appear on the clock edge after the one that captures the input, with `outValid` high.
- R2: Add (011011) returns F+W mod 256. C is the carry out of bit 7, HC is the carry out of bit 3, and Z is set when the result is zero.
- R3: Subtract (011100) returns F−W. C is set when no borrow leaves bit 7 (F≥W) and HC is set when no borrow leaves bit 3 (F[3:0]≥W[3:0]). Z is set when the result is zero.
- R4: Load F (011000), increment (011001), decrement (011101), AND (010010), OR (010011), XOR (010100) with W, and complement (011111) update only Z. `cOut` and `hcOut` equal `cIn` and `hcIn`.
- R5: Rotate right (010110) gives {C, F[7:1]} and the new C is F[0]. Rotate left (010101) gives {F[6:0], C} and the new C is F[7]. HC and Z pass through unchanged.
- R6: Swap (010111) exchanges the two nibbles of F and leaves all flags unchanged.
- R7: Increment-skip (011010) and decrement-skip (011110) write F±1, raise `skipReq` when the result is zero, and leave all flags unchanged.
- R8: The literal forms take the operand from bits 7:0 and always write W. Load literal (111010) leaves the flags unchanged. AND (110100), OR (110101) and XOR (110110) with a literal update only Z.
- R9: When bits 13:12 are 00, bits 11:10 select the bit operation and bits 9:7 give the bit index. 00 clears the bit and 10 sets it. Both write the file register and leave the flags unchanged.
- R10: Bit-test forms 01 (skip if clear) and 11 (skip if set) raise `skipReq` on the stated condition. They never assert `wrEn`.
- R11: Opcode 010000 with bit 7 set clears W and sets Z. Opcode 010001 with bit 7 set stores W to the file register with no flag change. With bit 7 clear it clears the register and sets Z.
- R12: Opcode 010000 with low byte 0x00, 0x01, 0x02, 0x03 or 0x04 raises `ctlStrobe` bit 0 (no-op), 1 (watchdog clear), 2 (sleep), 3 (timer-mode load) or 4 (return). Low byte 0x05–0x07 raises bit 5 (port-direction load). The other strobe bits stay low, and no write or skip occurs.
- R13: Any other encoding gives `outValid`=1, `wrEn`=0, `skipReq`=0 and `ctlStrobe`=0, with the flags equal to the inputs.
- R14: A cycle with `inValid` low gives `outValid`, `wrEn`, `skipReq` and `ctlStrobe` all low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction present this cycle |
| instr | input | 14 | Instruction word |
| wReg | input | 8 | Working register value |
| fileVal | input | 8 | Operand read from the addressed file register |
| cIn | input | 1 | Current carry flag |
| hcIn | input | 1 | Current half-carry flag |
| zIn | input | 1 | Current zero flag |
| outValid | output | 1 | Registered outputs belong to a decoded instruction |
| result | output | 8 | Value to write back |
| wrEn | output | 1 | Write-back required |
| toFile | output | 1 | 1: write the file register, 0: write W |
| cOut | output | 1 | Next carry flag |
| hcOut | output | 1 | Next half-carry flag |
| zOut | output | 1 | Next zero flag |
| skipReq | output | 1 | Skip the next instruction |
| ctlStrobe | output | 6 | One-hot control-opcode match |

## Verification
The assertions assume that `instr`, `wReg`, `fileVal` and the flag inputs are known and stable at every sampled edge while `inValid` is high. They also assume that the register file has already resolved the operand for the instruction being presented. The bench drives all inputs on the falling edge, so every input is settled a half period before the capturing edge. The bench supplies the operand directly instead of modelling any storage. Idle cycles between instructions exercise the quiet state.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;
  localparam int DataW  = 8;
  localparam int InstrW = 14;
  localparam int CtlN   = 6;
  localparam int IdxW   = $clog2(DataW);

  typedef enum logic [4:0] {
    OP_PASS, OP_PASSW, OP_SWAP, OP_INC, OP_DEC, OP_ADD, OP_SUB,
    OP_AND, OP_IOR, OP_XOR, OP_COM, OP_RRC, OP_RLC, OP_ZERO,
    OP_BCLR, OP_BSET
  } aluOpT;

  typedef struct packed {
    aluOpT            op;
    logic             useLit;
    logic             wrEn;
    logic             toFile;
    logic             updC;
    logic             updHc;
    logic             updZ;
    logic             skipZero;
    logic             skipBitClr;
    logic             skipBitSet;
    logic [CtlN-1:0]  ctl;
  } ctlBundleT;
endpackage

// File: rtl/alu_exec_ctrl.sv
module alu_exec_ctrl
  import alu_exec_pkg::*;
(
  input  logic [InstrW-1:0] instr,
  output ctlBundleT         ctlBus
);
  logic [5:0] opHi;
  logic [7:0] lowByte;

  assign opHi    = instr[13:8];
  assign lowByte = instr[7:0];

  always_comb begin
    ctlBus = '0;
    ctlBus.op = OP_PASS;
    if (instr[13:12] == 2'b00) begin
      unique case (instr[11:10])
        2'b00: begin ctlBus.op = OP_BCLR; ctlBus.wrEn = 1'b1; ctlBus.toFile = 1'b1; end
        2'b10: begin ctlBus.op = OP_BSET; ctlBus.wrEn = 1'b1; ctlBus.toFile = 1'b1; end
        2'b01: ctlBus.skipBitClr = 1'b1;
        default: ctlBus.skipBitSet = 1'b1;
      endcase
    end else begin
      case (opHi)
        6'b010000: begin
          if (lowByte[7]) begin
            ctlBus.op = OP_ZERO; ctlBus.wrEn = 1'b1; ctlBus.updZ = 1'b1;
          end else begin
            case (lowByte)
              8'h00: ctlBus.ctl[0] = 1'b1;
              8'h01: ctlBus.ctl[1] = 1'b1;
              8'h02: ctlBus.ctl[2] = 1'b1;
              8'h03: ctlBus.ctl[3] = 1'b1;
              8'h04: ctlBus.ctl[4] = 1'b1;
              8'h05, 8'h06, 8'h07: ctlBus.ctl[5] = 1'b1;
              default: ;
            endcase
          end
        end
        6'b010001: begin
          ctlBus.wrEn = 1'b1; ctlBus.toFile = 1'b1;
          if (lowByte[7]) ctlBus.op = OP_PASSW;
          else begin ctlBus.op = OP_ZERO; ctlBus.updZ = 1'b1; end
        end
        6'b011000, 6'b011001, 6'b011101, 6'b010010, 6'b010011,
        6'b010100, 6'b011111: begin
          ctlBus.wrEn = 1'b1; ctlBus.toFile = instr[7]; ctlBus.updZ = 1'b1;
          case (opHi)
            6'b011001: ctlBus.op = OP_INC;
            6'b011101: ctlBus.op = OP_DEC;
            6'b010010: ctlBus.op = OP_AND;
            6'b010011: ctlBus.op = OP_IOR;
            6'b010100: ctlBus.op = OP_XOR;
            6'b011111: ctlBus.op = OP_COM;
            default:   ctlBus.op = OP_PASS;
          endcase
        end
        6'b011011, 6'b011100: begin
          ctlBus.wrEn = 1'b1; ctlBus.toFile = instr[7];
          ctlBus.updC = 1'b1; ctlBus.updHc = 1'b1; ctlBus.updZ = 1'b1;
          ctlBus.op = opHi[0] ? OP_ADD : OP_SUB;
        end
        6'b010110, 6'b010101: begin
          ctlBus.wrEn = 1'b1; ctlBus.toFile = instr[7]; ctlBus.updC = 1'b1;
          ctlBus.op = (opHi == 6'b010110) ? OP_RRC : OP_RLC;
        end
        6'b010111: begin
          ctlBus.wrEn = 1'b1; ctlBus.toFile = instr[7]; ctlBus.op = OP_SWAP;
        end
        6'b011010, 6'b011110: begin
          ctlBus.wrEn = 1'b1; ctlBus.toFile = instr[7]; ctlBus.skipZero = 1'b1;
          ctlBus.op = (opHi == 6'b011010) ? OP_INC : OP_DEC;
        end
        6'b111010, 6'b110100, 6'b110101, 6'b110110: begin
          ctlBus.wrEn = 1'b1; ctlBus.useLit = 1'b1;
          ctlBus.updZ = (opHi != 6'b111010);
          case (opHi)
            6'b110100: ctlBus.op = OP_AND;
            6'b110101: ctlBus.op = OP_IOR;
            6'b110110: ctlBus.op = OP_XOR;
            default:   ctlBus.op = OP_PASS;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/alu_exec_dp.sv
module alu_exec_dp
  import alu_exec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  ctlBundleT          ctlBus,
  input  logic [DataW-1:0]   litVal,
  input  logic [IdxW-1:0]    bitIdx,
  input  logic [DataW-1:0]   wReg,
  input  logic [DataW-1:0]   fileVal,
  input  logic               cIn,
  input  logic               hcIn,
  input  logic               zIn,
  output logic               outValid,
  output logic [DataW-1:0]   result,
  output logic               wrEn,
  output logic               toFile,
  output logic               cOut,
  output logic               hcOut,
  output logic               zOut,
  output logic               skipReq,
  output logic [CtlN-1:0]    ctlStrobe
);
  localparam int HalfW = DataW / 2;

  logic [DataW-1:0] opA, res, bitMask;
  logic             cNew, hcNew, tested, skipNew;
  logic [DataW:0]   sumWide;
  logic [HalfW:0]   sumHalf;

  assign opA     = ctlBus.useLit ? litVal : fileVal;
  assign bitMask = DataW'(1) << bitIdx;
  assign tested  = fileVal[bitIdx];

  always_comb begin
    res     = opA;
    cNew    = cIn;
    hcNew   = hcIn;
    sumWide = '0;
    sumHalf = '0;
    unique case (ctlBus.op)
      OP_PASSW: res = wReg;
      OP_SWAP:  res = {opA[HalfW-1:0], opA[DataW-1:HalfW]};
      OP_INC:   res = opA + 1'b1;
      OP_DEC:   res = opA - 1'b1;
      OP_ADD: begin
        sumWide = {1'b0, opA} + {1'b0, wReg};
        sumHalf = {1'b0, opA[HalfW-1:0]} + {1'b0, wReg[HalfW-1:0]};
        res = sumWide[DataW-1:0]; cNew = sumWide[DataW]; hcNew = sumHalf[HalfW];
      end
      OP_SUB: begin
        sumWide = {1'b0, opA} + {1'b0, ~wReg} + 1'b1;
        sumHalf = {1'b0, opA[HalfW-1:0]} + {1'b0, ~wReg[HalfW-1:0]} + 1'b1;
        res = sumWide[DataW-1:0]; cNew = sumWide[DataW]; hcNew = sumHalf[HalfW];
      end
      OP_AND:  res = opA & wReg;
      OP_IOR:  res = opA | wReg;
      OP_XOR:  res = opA ^ wReg;
      OP_COM:  res = ~opA;
      OP_RRC: begin res = {cIn, opA[DataW-1:1]}; cNew = opA[0]; end
      OP_RLC: begin res = {opA[DataW-2:0], cIn}; cNew = opA[DataW-1]; end
      OP_ZERO: res = '0;
      OP_BCLR: res = opA & ~bitMask;
      OP_BSET: res = opA | bitMask;
      default: res = opA;
    endcase
  end

  assign skipNew = (ctlBus.skipZero && res == '0) ||
                   (ctlBus.skipBitClr && !tested) ||
                   (ctlBus.skipBitSet && tested);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0; result <= '0; wrEn <= 1'b0; toFile <= 1'b0;
      cOut <= 1'b0; hcOut <= 1'b0; zOut <= 1'b0; skipReq <= 1'b0; ctlStrobe <= '0;
    end else begin
      outValid  <= inValid;
      result    <= res;
      wrEn      <= inValid && ctlBus.wrEn;
      toFile    <= ctlBus.toFile;
      cOut      <= ctlBus.updC  ? cNew  : cIn;
      hcOut     <= ctlBus.updHc ? hcNew : hcIn;
      zOut      <= ctlBus.updZ  ? (res == '0) : zIn;
      skipReq   <= inValid && skipNew;
      ctlStrobe <= inValid ? ctlBus.ctl : '0;
    end
  end

  a_r12_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctlStrobe));
  a_r12_strobe_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStrobe != '0) |-> (!wrEn && !skipReq));
  a_r10_skip_test_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (ctlBus.skipBitClr || ctlBus.skipBitSet)) |=> !wrEn);
  a_r14_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !wrEn && !skipReq && ctlStrobe == '0));
endmodule

// File: rtl/alu_exec_top.sv
module alu_exec_top
  import alu_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [13:0]       instr,
  input  logic [7:0]        wReg,
  input  logic [7:0]        fileVal,
  input  logic              cIn,
  input  logic              hcIn,
  input  logic              zIn,
  output logic              outValid,
  output logic [7:0]        result,
  output logic              wrEn,
  output logic              toFile,
  output logic              cOut,
  output logic              hcOut,
  output logic              zOut,
  output logic              skipReq,
  output logic [5:0]        ctlStrobe
);
  ctlBundleT ctlBus;

  alu_exec_ctrl u_ctrl (.instr(instr), .ctlBus(ctlBus));

  alu_exec_dp u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctlBus(ctlBus),
    .litVal(instr[DataW-1:0]), .bitIdx(instr[9:7]),
    .wReg(wReg), .fileVal(fileVal), .cIn(cIn), .hcIn(hcIn), .zIn(zIn),
    .outValid(outValid), .result(result), .wrEn(wrEn), .toFile(toFile),
    .cOut(cOut), .hcOut(hcOut), .zOut(zOut), .skipReq(skipReq),
    .ctlStrobe(ctlStrobe)
  );

  a_r8_literal_to_w: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instr[13:8] == 6'b110100) |=> (wrEn && !toFile));
  a_r5_rotate_keeps_z: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instr[13:8] == 6'b010110) |=> (zOut == $past(zIn) && hcOut == $past(hcIn)));
  a_r1_dest_bit: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instr[13:8] == 6'b011011) |=> (wrEn && toFile == $past(instr[7])));
endmodule

// File: tb/test_alu_exec_top.sv
module test_alu_exec_top;
  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0;
  logic [13:0] instr = '0;
  logic [7:0] wReg = '0, fileVal = '0;
  logic cIn = 1'b0, hcIn = 1'b0, zIn = 1'b0;
  logic outValid, wrEn, toFile, cOut, hcOut, zOut, skipReq;
  logic [7:0] result;
  logic [5:0] ctlStrobe;

  int total = 0, bad = 0;

  typedef struct {
    logic v; logic we; logic tf; logic [7:0] r;
    logic c; logic hc; logic z; logic sk; logic [5:0] st; string tag;
  } expT;

  expT sbq[$];

  always #5 clk = ~clk;

  alu_exec_top i_alu_exec_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr), .wReg(wReg),
    .fileVal(fileVal), .cIn(cIn), .hcIn(hcIn), .zIn(zIn), .outValid(outValid),
    .result(result), .wrEn(wrEn), .toFile(toFile), .cOut(cOut), .hcOut(hcOut),
    .zOut(zOut), .skipReq(skipReq), .ctlStrobe(ctlStrobe)
  );

  function automatic expT model(logic [13:0] ins, logic [7:0] w, logic [7:0] f,
                                logic c, logic hc, logic z, string tag);
    expT e;
    logic [8:0] s9; logic [4:0] s5; logic [7:0] lit;
    e.v = 1; e.we = 0; e.tf = 0; e.r = 0; e.c = c; e.hc = hc; e.z = z;
    e.sk = 0; e.st = 0; e.tag = tag; lit = ins[7:0];
    if (ins[13:12] == 2'b00) begin
      case (ins[11:10])
        2'b00: begin e.we = 1; e.tf = 1; e.r = f; e.r[ins[9:7]] = 0; end
        2'b10: begin e.we = 1; e.tf = 1; e.r = f; e.r[ins[9:7]] = 1; end
        2'b01: e.sk = !f[ins[9:7]];
        default: e.sk = f[ins[9:7]];
      endcase
      return e;
    end
    case (ins[13:8])
      6'b011011: begin s9 = f + w; s5 = f[3:0] + w[3:0];
        e.we = 1; e.tf = ins[7]; e.r = s9[7:0]; e.c = s9[8]; e.hc = s5[4]; e.z = (e.r == 0); end
      6'b011100: begin e.we = 1; e.tf = ins[7]; e.r = f - w;
        e.c = (f >= w); e.hc = (f[3:0] >= w[3:0]); e.z = (e.r == 0); end
      6'b011000: begin e.we = 1; e.tf = ins[7]; e.r = f; e.z = (e.r == 0); end
      6'b011001: begin e.we = 1; e.tf = ins[7]; e.r = f + 1; e.z = (e.r == 0); end
      6'b011101: begin e.we = 1; e.tf = ins[7]; e.r = f - 1; e.z = (e.r == 0); end
      6'b010010: begin e.we = 1; e.tf = ins[7]; e.r = f & w; e.z = (e.r == 0); end
      6'b010011: begin e.we = 1; e.tf = ins[7]; e.r = f | w; e.z = (e.r == 0); end
      6'b010100: begin e.we = 1; e.tf = ins[7]; e.r = f ^ w; e.z = (e.r == 0); end
      6'b011111: begin e.we = 1; e.tf = ins[7]; e.r = ~f; e.z = (e.r == 0); end
      6'b010110: begin e.we = 1; e.tf = ins[7]; e.r = {c, f[7:1]}; e.c = f[0]; end
      6'b010101: begin e.we = 1; e.tf = ins[7]; e.r = {f[6:0], c}; e.c = f[7]; end
      6'b010111: begin e.we = 1; e.tf = ins[7]; e.r = {f[3:0], f[7:4]}; end
      6'b011010: begin e.we = 1; e.tf = ins[7]; e.r = f + 1; e.sk = (e.r == 0); end
      6'b011110: begin e.we = 1; e.tf = ins[7]; e.r = f - 1; e.sk = (e.r == 0); end
      6'b111010: begin e.we = 1; e.r = lit; end
      6'b110100: begin e.we = 1; e.r = lit & w; e.z = (e.r == 0); end
      6'b110101: begin e.we = 1; e.r = lit | w; e.z = (e.r == 0); end
      6'b110110: begin e.we = 1; e.r = lit ^ w; e.z = (e.r == 0); end
      6'b010000: begin
        if (lit[7]) begin e.we = 1; e.r = 0; e.z = 1; end
        else if (lit <= 8'h04) e.st = 6'b1 << lit;
        else if (lit <= 8'h07) e.st = 6'b100000;
      end
      6'b010001: begin e.we = 1; e.tf = 1;
        if (lit[7]) e.r = w; else begin e.r = 0; e.z = 1; end end
      default: ;
    endcase
    return e;
  endfunction

  task automatic send(logic [13:0] ins, logic [7:0] w, logic [7:0] f,
                      logic c, logic hc, logic z, string tag);
    @(negedge clk);
    inValid = 1; instr = ins; wReg = w; fileVal = f; cIn = c; hcIn = hc; zIn = z;
    sbq.push_back(model(ins, w, f, c, hc, z, tag));
  endtask

  task automatic idle(string tag);
    expT e;
    @(negedge clk);
    inValid = 0; instr = 14'h3FFF; wReg = 8'hFF; fileVal = 8'hFF;
    e.v = 0; e.we = 0; e.tf = 0; e.r = 0; e.c = 0; e.hc = 0; e.z = 0;
    e.sk = 0; e.st = 0; e.tag = tag;
    sbq.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      expT e;
      logic ok;
      e = sbq.pop_front();
      total++;
      if (!e.v)
        ok = (outValid === 0 && wrEn === 0 && skipReq === 0 && ctlStrobe === 0);
      else
        ok = (outValid === 1 && wrEn === e.we && skipReq === e.sk && ctlStrobe === e.st &&
              cOut === e.c && hcOut === e.hc && zOut === e.z &&
              (!e.we || (result === e.r && toFile === e.tf)));
      if (!ok) begin
        bad++;
        $display("FAIL %s: got v=%b we=%b tf=%b r=%h c=%b hc=%b z=%b sk=%b st=%b exp v=%b we=%b tf=%b r=%h c=%b hc=%b z=%b sk=%b st=%b",
          e.tag, outValid, wrEn, toFile, result, cOut, hcOut, zOut, skipReq, ctlStrobe,
          e.v, e.we, e.tf, e.r, e.c, e.hc, e.z, e.sk, e.st);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (outValid !== 0 || wrEn !== 0 || skipReq !== 0 || ctlStrobe !== 0) begin
      bad++;
      $display("FAIL R14 reset: got v=%b we=%b sk=%b st=%b exp all zero", outValid, wrEn, skipReq, ctlStrobe);
    end
    rstN = 1;
    // R1 destination bit
    send({6'b011000, 1'b0, 7'h12}, 8'h00, 8'h5A, 0, 0, 1, "R1");
    send({6'b011000, 1'b1, 7'h12}, 8'h00, 8'h00, 0, 0, 0, "R1");
    // R2 add corners
    send({6'b011011, 1'b1, 7'h20}, 8'h80, 8'h80, 0, 1, 0, "R2");
    send({6'b011011, 1'b0, 7'h20}, 8'h01, 8'h0F, 1, 0, 1, "R2");
    send({6'b011011, 1'b0, 7'h20}, 8'h22, 8'h33, 1, 1, 1, "R2");
    // R3 subtract corners
    send({6'b011100, 1'b0, 7'h20}, 8'h05, 8'h05, 0, 0, 0, "R3");
    send({6'b011100, 1'b1, 7'h20}, 8'h05, 8'h03, 1, 1, 1, "R3");
    send({6'b011100, 1'b0, 7'h20}, 8'h00, 8'h9C, 0, 0, 1, "R3");
    send({6'b011100, 1'b0, 7'h20}, 8'h18, 8'h21, 0, 0, 0, "R3");
    // R4 Z-only group
    send({6'b011001, 1'b0, 7'h11}, 8'h00, 8'hFF, 1, 1, 0, "R4");
    send({6'b011101, 1'b1, 7'h11}, 8'h00, 8'h00, 0, 1, 1, "R4");
    send({6'b010010, 1'b0, 7'h11}, 8'hF0, 8'h0F, 1, 0, 0, "R4");
    send({6'b010011, 1'b0, 7'h11}, 8'hF0, 8'h0F, 0, 1, 1, "R4");
    send({6'b010100, 1'b1, 7'h11}, 8'hA5, 8'hA5, 1, 1, 0, "R4");
    send({6'b011111, 1'b0, 7'h11}, 8'h00, 8'hFF, 0, 0, 0, "R4");
    // R5 rotates
    send({6'b010110, 1'b1, 7'h11}, 8'h00, 8'h01, 1, 1, 0, "R5");
    send({6'b010110, 1'b0, 7'h11}, 8'h00, 8'h80, 0, 0, 1, "R5");
    send({6'b010101, 1'b0, 7'h11}, 8'h00, 8'h80, 0, 1, 1, "R5");
    send({6'b010101, 1'b1, 7'h11}, 8'h00, 8'h40, 1, 0, 0, "R5");
    // R6 swap
    send({6'b010111, 1'b0, 7'h11}, 8'h00, 8'h3C, 1, 0, 1, "R6");
    // R7 skip on zero
    send({6'b011010, 1'b1, 7'h11}, 8'h00, 8'hFF, 0, 1, 0, "R7");
    send({6'b011010, 1'b1, 7'h11}, 8'h00, 8'h10, 0, 1, 0, "R7");
    send({6'b011110, 1'b0, 7'h11}, 8'h00, 8'h01, 1, 0, 0, "R7");
    send({6'b011110, 1'b0, 7'h11}, 8'h00, 8'h00, 1, 0, 1, "R7");
    // R8 literals
    send({6'b111010, 8'h00}, 8'h77, 8'h11, 0, 0, 0, "R8");
    send({6'b110100, 8'h0F}, 8'hF0, 8'h11, 1, 1, 0, "R8");
    send({6'b110101, 8'h81}, 8'h18, 8'hFF, 0, 0, 1, "R8");
    send({6'b110110, 8'hAA}, 8'hAA, 8'h00, 0, 0, 0, "R8");
    idle("R14");
    // R9 bit set/clear
    send({4'b0000, 3'd7, 7'h05}, 8'h00, 8'hFF, 1, 1, 0, "R9");
    send({4'b0010, 3'd0, 7'h05}, 8'h00, 8'h00, 0, 0, 1, "R9");
    send({4'b0010, 3'd4, 7'h05}, 8'h00, 8'h10, 0, 1, 0, "R9");
    // R10 bit tests
    send({4'b0001, 3'd3, 7'h05}, 8'h00, 8'hF7, 0, 0, 0, "R10");
    send({4'b0001, 3'd3, 7'h05}, 8'h00, 8'h08, 0, 0, 0, "R10");
    send({4'b0011, 3'd6, 7'h05}, 8'h00, 8'h40, 0, 0, 0, "R10");
    send({4'b0011, 3'd6, 7'h05}, 8'h00, 8'hBF, 0, 0, 0, "R10");
    // R11 clear/store group
    send({6'b010000, 8'h80}, 8'h55, 8'h66, 1, 1, 0, "R11");
    send({6'b010001, 8'h85}, 8'h55, 8'h66, 1, 1, 0, "R11");
    send({6'b010001, 8'h05}, 8'h55, 8'h66, 1, 1, 0, "R11");
    // R12 control strobes
    for (int k = 0; k < 8; k++)
      send({6'b010000, 8'(k)}, 8'h12, 8'h34, 1, 0, 1, "R12");
    // R13 unrecognised encodings
    send({6'b010000, 8'h08}, 8'h12, 8'h34, 1, 1, 0, "R13");
    send({6'b010000, 8'h7F}, 8'h12, 8'h34, 0, 1, 1, "R13");
    send({6'b101010, 8'h55}, 8'h12, 8'h34, 1, 0, 0, "R13");
    send({6'b111111, 8'h00}, 8'h12, 8'h00, 0, 0, 1, "R13");
    // R14 idle cycles
    idle("R14");
    idle("R14");
    send({6'b011011, 1'b1, 7'h20}, 8'h01, 8'h01, 0, 0, 0, "R2");
    idle("R14");
    @(negedge clk);
    inValid = 0;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule